// File: doc/BRIEF.md
# I2C Configuration Slave with Deferred Commit

This block is a two-wire (I2C) target that holds three small configuration registers for a multiphase clock generator. The registers are a control byte (prescaler, phase mode, dither amount and dither rate fields), a 4-bit frequency code, and an address register. The address register carries a write-control flag and the three low bits of the block's own bus address. Beside the working registers sits a model of nonvolatile backup storage. A power-on reset loads that backup with the factory values. An ordinary reset reloads the working registers from the backup, so only what was saved survives a reset.

SCL and SDA arrive as raw levels and are oversampled on the system clock. The block reports SDA through a pull-down enable, and the pad logic outside turns that into an open-drain driver. A write is a start, the address byte with R/W=0, the register pointer, one data byte and a stop. A read is the same first two bytes, then a repeated start, the address byte with R/W=1 and one byte returned, which the master closes with a NACK.

The write-control flag picks the save policy. When it is clear, each register write is saved to the backup at the closing stop. When it is set, writes touch only the working copy until the master sends the save command (pointer 3Fh with no data). Writes to the address register are always saved. A save holds the block busy for a fixed number of clock ticks, and during that time it refuses its address. A master can therefore poll with bare address bytes until it gets an ACK.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The block answers to the 7-bit address 1011 followed by its 3-bit device select (MSB first, R/W as the eighth bit; B0h is the default write byte). On any other address it leaves SDA released for that byte's ACK slot, and for every byte that follows, until the next start condition. Bytes sent in that time change no register.
- R2: In a write, the block ACKs (drives 0 in the 9th bit) the address byte, the register pointer and the data byte. Bits are taken on SCL rising edges, MSB first. The data byte lands in the register that the pointer names.
- R3: A read returns the register that the pointer named in the preceding dummy write, MSB first, with each bit driven after SCL falls. Readback formats: pointer 02h returns the full control byte; 08h returns {1111, frequency code}; 0Dh returns {1111, write-control flag, device select[2:0]}. Any other pointer reads FFh, and writes to it are ignored.
- R4: After power-on reset, the control byte is CDh, the frequency code is 0, the write-control flag is 0, the device select is 0, and SDA is released.
- R5: The ordinary reset (rst_n) reloads all working registers from the backup model, and the backup keeps its contents.
- R6: With the write-control flag at 0, a register write is saved to the backup at the stop that ends it. With the flag at 1, a write to 02h or 08h changes only the working copy.
- R7: A write to 0Dh is always saved to the backup, whatever the flag's value.
- R8: A write transaction whose pointer is 3Fh, with no data byte, saves all three working registers to the backup at its stop.
- R9: A stop that saves anything starts a busy window of BUSY_TICKS clock cycles. During that window the block does not ACK its address. A stop that saves nothing starts no busy window.
- R10: The SDA pull-down changes only while SCL is low. Outside ACK slots and the zero bits of a read byte, it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; reloads the working registers from the backup |
| por_n | input | 1 | Synchronous active-low power-on reset of the backup model to the factory values |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level, as seen on the wired bus |
| sda_pull | output | 1 | 1 = pull SDA low |
| ctl_q | output | 8 | Working control byte (rate[7:6], phase[5:4], dither[3:2], prescale[1:0]) |
| freq_q | output | 4 | Working frequency code |
| wc_q | output | 1 | Working write-control flag |
| dev_q | output | 3 | Working device select (low address bits) |

## Verification
Four properties are checked on every cycle: SDA only moves while SCL is low, the pull-down stays off for the whole busy window, every busy window starts at a bus stop, and the working control and frequency registers change only after a decoded write. The remaining behaviours depend on what the backup holds, and only the bench's scenarios can show them. These are the split between saved and deferred writes, the save command, and the address register's forced save. Each scenario pulses the ordinary reset and compares the reloaded registers. The scenarios also cover ACK polling through a busy window, the address change, and the silence after a foreign address.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  // Register pointers; the master addresses them by these values.
  localparam logic [7:0] PTR_CTL  = 8'h02;
  localparam logic [7:0] PTR_FREQ = 8'h08;
  localparam logic [7:0] PTR_ADDR = 8'h0D;
  localparam logic [7:0] PTR_SAVE = 8'h3F;

  // Fixed upper part of the 7-bit bus address.
  localparam logic [3:0] DEV_PREFIX = 4'b1011;

  // Factory values held by the backup model after power-on.
  localparam logic [7:0] CTL_FACTORY  = 8'hCD;
  localparam logic [3:0] FREQ_FACTORY = 4'h0;
  localparam logic       WC_FACTORY   = 1'b0;
  localparam logic [2:0] DEV_FACTORY  = 3'b000;

  // Save-pending mask bit positions.
  localparam int SLOT_CTL  = 0;
  localparam int SLOT_FREQ = 1;
  localparam int SLOT_ADDR = 2;
  localparam int NUM_SLOTS = 3;

  typedef struct packed {
    logic [7:0] ctl;
    logic [3:0] freq;
    logic       wc;
    logic [2:0] dev;
  } cfg_regs_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_REG, S_REG_ACK,
    S_DATA, S_DATA_ACK, S_TX, S_TX_ACK
  } eng_state_t;

endpackage

// File: rtl/cfg_i2c_sense.sv
module cfg_i2c_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_s;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks the frame boundaries.
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic [2:0] dev_sel,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic [7:0] reg_ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       save_cmd,
  output logic       sda_pull
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  eng_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] txsh;
  logic       ack_q;
  logic       rw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txsh     <= '1;
      ack_q    <= 1'b0;
      rw_q     <= 1'b0;
      reg_ptr  <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      save_cmd <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      save_cmd <= 1'b0;
      if (start_p) begin
        state   <= S_DEV;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
        txsh    <= '1;
      end else if (stop_p) begin
        state <= S_IDLE;
        ack_q <= 1'b0;
        txsh  <= '1;
      end else begin
        unique case (state)
          S_DEV, S_REG, S_DATA: begin
            if (scl_rise && bit_cnt != BYTE_BITS) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == BYTE_BITS) begin
              bit_cnt <= '0;
              if (state == S_DEV) begin
                if (shreg[7:1] == {DEV_PREFIX, dev_sel} && !busy) begin
                  ack_q <= 1'b1;
                  rw_q  <= shreg[0];
                  state <= S_DEV_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_REG) begin
                reg_ptr  <= shreg;
                save_cmd <= (shreg == PTR_SAVE);
                ack_q    <= 1'b1;
                state    <= S_REG_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                ack_q   <= 1'b1;
                state   <= S_DATA_ACK;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              if (rw_q) begin
                txsh  <= rd_data;
                state <= S_TX;
              end else begin
                state <= S_REG;
              end
            end
          end
          S_REG_ACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              state <= S_DATA;
            end
          end
          S_DATA_ACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              state <= S_IDLE;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == BYTE_BITS) begin
                bit_cnt <= '0;
                txsh    <= '1;
                state   <= S_TX_ACK;
              end else begin
                txsh <= {txsh[6:0], 1'b1};
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_pull = ack_q | ((state == S_TX) & ~txsh[7]);

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int BUSY_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       save_cmd,
  input  logic       stop_p,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output cfg_regs_t  work
);

  localparam int CNT_W = $clog2(BUSY_TICKS + 1);
  localparam cfg_regs_t FACTORY = '{ctl: CTL_FACTORY, freq: FREQ_FACTORY,
                                    wc: WC_FACTORY, dev: DEV_FACTORY};

  cfg_regs_t              backup;
  logic [NUM_SLOTS-1:0]   pend;
  logic [CNT_W-1:0]       cnt;
  logic                   commit;

  assign commit = stop_p && (pend != '0);

  // Backup model: only power-on clears it; a committing stop copies
  // the pending slots from the working set.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      backup <= FACTORY;
    end else if (commit) begin
      if (pend[SLOT_CTL])  backup.ctl  <= work.ctl;
      if (pend[SLOT_FREQ]) backup.freq <= work.freq;
      if (pend[SLOT_ADDR]) begin
        backup.wc  <= work.wc;
        backup.dev <= work.dev;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work <= backup;
    end else if (wr_en) begin
      case (wr_addr)
        PTR_CTL:  work.ctl  <= wr_data;
        PTR_FREQ: work.freq <= wr_data[3:0];
        PTR_ADDR: {work.wc, work.dev} <= wr_data[3:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      cnt  <= '0;
    end else begin
      if (stop_p) begin
        pend <= '0;
      end else if (save_cmd) begin
        pend <= '1;
      end else if (wr_en) begin
        case (wr_addr)
          PTR_CTL:  pend[SLOT_CTL]  <= pend[SLOT_CTL]  | ~work.wc;
          PTR_FREQ: pend[SLOT_FREQ] <= pend[SLOT_FREQ] | ~work.wc;
          PTR_ADDR: pend[SLOT_ADDR] <= 1'b1;
          default:  ;
        endcase
      end
      if (commit) begin
        cnt <= CNT_W'(BUSY_TICKS);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign busy = (cnt != '0);

  always_comb begin
    case (rd_addr)
      PTR_CTL:  rd_data = work.ctl;
      PTR_FREQ: rd_data = {4'hF, work.freq};
      PTR_ADDR: rd_data = {4'hF, work.wc, work.dev};
      default:  rd_data = 8'hFF;
    endcase
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int BUSY_TICKS  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic [7:0] ctl_q,
  output logic [3:0] freq_q,
  output logic       wc_q,
  output logic [2:0] dev_q
);

  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_p;
  logic       stop_p;
  logic       busy;
  logic [7:0] reg_ptr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       save_cmd;
  logic [7:0] rd_data;
  cfg_regs_t  work;

  cfg_i2c_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  cfg_i2c_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .dev_sel  (work.dev),
    .busy     (busy),
    .rd_data  (rd_data),
    .reg_ptr  (reg_ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .save_cmd (save_cmd),
    .sda_pull (sda_pull)
  );

  cfg_i2c_regfile #(.BUSY_TICKS(BUSY_TICKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .wr_addr  (reg_ptr),
    .wr_data  (wr_data),
    .save_cmd (save_cmd),
    .stop_p   (stop_p),
    .rd_addr  (reg_ptr),
    .rd_data  (rd_data),
    .busy     (busy),
    .work     (work)
  );

  assign ctl_q  = work.ctl;
  assign freq_q = work.freq;
  assign wc_q   = work.wc;
  assign dev_q  = work.dev;

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull,
  input logic       busy,
  input logic       stop_p,
  input logic       wr_en,
  input logic [7:0] ctl_q,
  input logic [3:0] freq_q
);

  // R10: the data line only moves while the clock line is low.
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);

  // R9: no acknowledge of any kind while a save is in progress.
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R9: a busy window only opens at a bus stop.
  assert_busy_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_p));

  // R2: working registers move only after a decoded data byte.
  assert_ctl_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q) |-> $past(wr_en));

  assert_freq_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_q) |-> $past(wr_en));

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_pull (sda_pull),
  .busy     (busy),
  .stop_p   (stop_p),
  .wr_en    (wr_en),
  .ctl_q    (ctl_q),
  .freq_q   (freq_q)
);

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;

  localparam int Q = 10;
  localparam logic [6:0] DEV0 = 7'h58;
  localparam logic [6:0] DEV5 = 7'h5D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull;
  logic [7:0] ctl_q;
  logic [3:0] freq_q;
  logic       wc_q;
  logic [2:0] dev_q;
  logic       pull_seen = 1'b0;
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;
  always @(posedge clk) if (sda_pull) pull_seen <= 1'b1;

  cfg_i2c_slave u_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .ctl_q(ctl_q), .freq_q(freq_q), .wc_q(wc_q), .dev_q(dev_q)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_cyc(Q); sda_m = 1'b0;
    wait_cyc(Q); scl_m = 1'b1;
    wait_cyc(Q); sda_m = 1'b1;
    wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(Q); sda_m = b[i];
      wait_cyc(Q); scl_m = 1'b1;
      wait_cyc(2 * Q); scl_m = 1'b0;
    end
    wait_cyc(Q); sda_m = 1'b1;
    wait_cyc(Q); scl_m = 1'b1;
    wait_cyc(Q); acked = ~sda_line;
    wait_cyc(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(Q); sda_m = 1'b1;
      wait_cyc(Q); scl_m = 1'b1;
      wait_cyc(Q); b[i] = sda_line;
      wait_cyc(Q); scl_m = 1'b0;
    end
    wait_cyc(Q); sda_m = 1'b1;
    wait_cyc(Q); scl_m = 1'b1;
    wait_cyc(2 * Q); scl_m = 1'b0;
  endtask

  task automatic write_reg(input logic [6:0] dev, input logic [7:0] ptr,
                           input logic [7:0] data, output logic [2:0] acks);
    logic a;
    acks = 3'b000;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    if (a) begin
      send_byte(ptr, a);  acks[1] = a;
      send_byte(data, a); acks[0] = a;
    end
    bus_stop();
  endtask

  task automatic read_reg(input logic [6:0] dev, input logic [7:0] ptr,
                          output logic [7:0] data, output logic [2:0] acks);
    logic a;
    acks = 3'b000;
    data = 8'h00;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    send_byte(ptr, a);         acks[1] = a;
    bus_start();
    send_byte({dev, 1'b1}, a); acks[0] = a;
    if (a) recv_byte(data);
    bus_stop();
  endtask

  task automatic poll(input logic [6:0] dev, output int tries);
    logic a;
    tries = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_byte({dev, 1'b0}, a);
      bus_stop();
      if (a) break;
      tries++;
    end
  endtask

  task automatic pulse_rst();
    rst_n = 1'b0; wait_cyc(4);
    rst_n = 1'b1; wait_cyc(4);
  endtask

  task automatic power_on();
    por_n = 1'b0; rst_n = 1'b0; wait_cyc(6);
    por_n = 1'b1; rst_n = 1'b1; wait_cyc(4);
  endtask

  task automatic t_reset_state();
    power_on();
    chk("R4 ctl", ctl_q, 8'hCD);
    chk("R4 freq", freq_q, 4'h0);
    chk("R4 wc", wc_q, 1'b0);
    chk("R4 dev", dev_q, 3'd0);
    chk("R4 sda released", sda_pull, 1'b0);
  endtask

  task automatic t_immediate_write();
    logic [2:0] acks;
    int tries;
    write_reg(DEV0, 8'h08, 8'h0A, acks);
    chk("R2 acks", acks, 3'b111);
    chk("R2 freq", freq_q, 4'hA);
    chk("R10 released after stop", sda_pull, 1'b0);
    poll(DEV0, tries);
    chk("R9 nack while busy", tries > 0, 1'b1);
    chk("R9 busy ends", tries < 40, 1'b1);
  endtask

  task automatic t_readback();
    logic [2:0] acks;
    logic [7:0] d;
    read_reg(DEV0, 8'h08, d, acks);
    chk("R3 acks", acks, 3'b111);
    chk("R3 freq readback", d, 8'hFA);
    read_reg(DEV0, 8'h02, d, acks);
    chk("R3 ctl readback", d, 8'hCD);
    read_reg(DEV0, 8'h0D, d, acks);
    chk("R3 addr readback", d, 8'hF0);
  endtask

  task automatic t_foreign_address();
    logic a1, a2, a3;
    pull_seen = 1'b0;
    bus_start();
    send_byte({7'h59, 1'b0}, a1);
    send_byte(8'h08, a2);
    send_byte(8'h05, a3);
    bus_stop();
    chk("R1 no ack", {a1, a2, a3}, 3'b000);
    chk("R1 sda never pulled", pull_seen, 1'b0);
    chk("R1 freq untouched", freq_q, 4'hA);
  endtask

  task automatic t_unmapped();
    logic [2:0] acks;
    logic [7:0] d;
    int tries;
    write_reg(DEV0, 8'h05, 8'h33, acks);
    chk("R3 unmapped write acked", acks, 3'b111);
    chk("R3 ctl unchanged", ctl_q, 8'hCD);
    chk("R3 freq unchanged", freq_q, 4'hA);
    poll(DEV0, tries);
    chk("R9 no busy without save", tries, 0);
    read_reg(DEV0, 8'h05, d, acks);
    chk("R3 unmapped reads FF", d, 8'hFF);
  endtask

  task automatic t_deferred();
    logic [2:0] acks;
    logic [7:0] d;
    int tries;
    write_reg(DEV0, 8'h0D, 8'h08, acks);
    chk("R7 wc set", wc_q, 1'b1);
    poll(DEV0, tries);
    chk("R7 addr write saves", tries > 0, 1'b1);
    write_reg(DEV0, 8'h02, 8'h5A, acks);
    chk("R6 ctl working", ctl_q, 8'h5A);
    poll(DEV0, tries);
    chk("R6 deferred no busy", tries, 0);
    read_reg(DEV0, 8'h02, d, acks);
    chk("R3 ctl readback 5A", d, 8'h5A);
    pulse_rst();
    chk("R6 ctl reverted", ctl_q, 8'hCD);
    chk("R7 wc kept", wc_q, 1'b1);
    chk("R5 freq reloaded", freq_q, 4'hA);
  endtask

  task automatic t_save_cmd();
    logic [2:0] acks;
    logic a1, a2;
    int tries;
    write_reg(DEV0, 8'h08, 8'h07, acks);
    write_reg(DEV0, 8'h02, 8'h3C, acks);
    poll(DEV0, tries);
    chk("R6 deferred no busy", tries, 0);
    bus_start();
    send_byte({DEV0, 1'b0}, a1);
    send_byte(8'h3F, a2);
    bus_stop();
    chk("R8 save acked", {a1, a2}, 2'b11);
    poll(DEV0, tries);
    chk("R8 save busy", tries > 0, 1'b1);
    pulse_rst();
    chk("R8 freq saved", freq_q, 4'h7);
    chk("R8 ctl saved", ctl_q, 8'h3C);
  endtask

  task automatic t_address_change();
    logic [2:0] acks;
    logic [7:0] d;
    int tries;
    write_reg(DEV0, 8'h0D, 8'h0D, acks);
    chk("R7 dev select", dev_q, 3'd5);
    poll(DEV5, tries);
    chk("R9 poll new address", tries > 0, 1'b1);
    poll(DEV0, tries);
    chk("R1 old address refused", tries, 40);
    read_reg(DEV5, 8'h0D, d, acks);
    chk("R3 addr readback FD", d, 8'hFD);
    pulse_rst();
    chk("R7 dev kept", dev_q, 3'd5);
  endtask

  task automatic t_power_cycle();
    logic [2:0] acks;
    logic [7:0] d;
    power_on();
    chk("R4 ctl after power-on", ctl_q, 8'hCD);
    chk("R4 freq after power-on", freq_q, 4'h0);
    chk("R4 dev after power-on", dev_q, 3'd0);
    read_reg(DEV0, 8'h08, d, acks);
    chk("R1 default address", acks, 3'b111);
    chk("R3 freq readback F0", d, 8'hF0);
  endtask

  initial begin
    t_reset_state();
    t_immediate_write();
    t_readback();
    t_foreign_address();
    t_unmapped();
    t_deferred();
    t_save_cmd();
    t_address_change();
    t_power_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule